// File: doc/BRIEF.md
# Debug Access Authentication Gate

This block sits in front of the register file of a debug module and decides which debugger writes may reach it. It keeps an authenticated flag, a 32-bit challenge and a fixed secret. To unlock, the debugger reads the challenge from the `challenge` port, adds the secret modulo 2^32, and writes the sum to the key register. A wrong key locks the gate and replaces the challenge with a fresh value from a free-running linear feedback shift register.

While the gate is locked, the key register and the control register are the only write targets it accepts. Even then, a control write changes only the module-active bit. The halt, resume, reset and hart-select fields keep their values. When the module-active bit goes from 0 to 1, the gate's state is re-initialised and a new challenge is drawn. The registers behind the gate are not part of this block: `wr_accept` tells them whether the current write may land.

Top module: `dbg_auth_gate`

## Requirements
- R1: With `REQUIRE_AUTH` = 0, `authed` is 1 from reset. No key write or control write ever clears it.
- R2: With `REQUIRE_AUTH` = 1, a write to `KEY_ADDR` whose data equals (`challenge` + `SECRET`) mod 2^32 sets `authed` one cycle later. A correct key leaves `challenge` unchanged.
- R3: With `REQUIRE_AUTH` = 1, a write to `KEY_ADDR` with any other data clears `authed`. In the same cycle it loads `challenge` with the generator value present at that write's clock edge.
- R4: `wr_accept` is high only during a write (`wr_en` = 1). While `authed` = 0 it is high only for `KEY_ADDR` and `CTRL_ADDR`. While `authed` = 1 it is high for every address.
- R5: While `authed` = 0, a control write that is not a 0-to-1 transition of `dm_active` sets `dm_active` to data bit 0. It leaves `halt_req`, `resume_req`, `hart_reset`, `sys_reset` and `hart_sel` unchanged.
- R6: A control write with data bit 0 = 1 while `dm_active` = 0 sets `dm_active` and loads `challenge` from the generator. It also sets `authed` to NOT `REQUIRE_AUTH`. When `REQUIRE_AUTH` = 1 it clears all other control fields. When `REQUIRE_AUTH` = 0 it loads them from the data.
- R7: While `authed` = 1, a control write with data bit 0 = 1 and `dm_active` already 1 loads the control fields from these data bits: `halt_req` from bit 31, `resume_req` from bit 30, `hart_reset` from bit 29, `sys_reset` from bit 1, and `hart_sel` from bits [25:16]. A write with bit 0 = 0 clears `dm_active` and holds the other fields.
- R8: The generator resets to `SEED` and advances once per cycle as a right-shifting Galois register: next = (g >> 1) XOR (g[0] ? 32'h80200003 : 0). It is never zero. `challenge` changes only on the writes of R3 and R6.
- R9: After reset, `challenge` = `SEED`, `dm_active` = 0, all control fields are 0, and `authed` = NOT `REQUIRE_AUTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the debug transport |
| wr_addr | input | AW | Register address of the write |
| wr_data | input | DW | Write data |
| wr_accept | output | 1 | Current write may update protected registers |
| authed | output | 1 | Authenticated status |
| challenge | output | DW | Current challenge, readable by the debugger |
| dm_active | output | 1 | Module-active control bit |
| halt_req | output | 1 | Halt request field |
| resume_req | output | 1 | Resume request field |
| hart_reset | output | 1 | Hart reset field |
| sys_reset | output | 1 | System reset field |
| hart_sel | output | HSW | Hart select field |

## Verification
The internal state that can go wrong is the challenge register or the generator behind it. Either error shows on the `challenge` port on the cycle after the first wrong key or the first module-active rising edge. From then on, every correct key computed by the debugger fails to unlock. A stuck or wrong authenticated flag shows at once on `wr_accept` for the next write to any address other than the key and control registers. Control fields that leak through while the gate is locked show on their own output pins one cycle after the control write.

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate #(
  parameter int unsigned DW           = 32,
  parameter int unsigned AW           = 7,
  parameter int unsigned HSW          = 10,
  parameter logic [6:0]  KEY_ADDR     = 7'h30,
  parameter logic [6:0]  CTRL_ADDR    = 7'h10,
  parameter logic [31:0] SECRET       = 32'hC3A5_9E71,
  parameter logic [31:0] SEED         = 32'h1ACE_B00C,
  parameter logic [31:0] TAPS         = 32'h8020_0003,
  parameter bit          REQUIRE_AUTH = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_accept,
  output logic           authed,
  output logic [DW-1:0]  challenge,
  output logic           dm_active,
  output logic           halt_req,
  output logic           resume_req,
  output logic           hart_reset,
  output logic           sys_reset,
  output logic [HSW-1:0] hart_sel
);
  localparam int unsigned HSEL_LSB = 16;

  logic [DW-1:0] lfsr_q, lfsr_nxt;
  logic          hit_key, hit_ctrl, key_ok, rise;

  assign hit_key   = wr_en && (wr_addr == KEY_ADDR[AW-1:0]);
  assign hit_ctrl  = wr_en && (wr_addr == CTRL_ADDR[AW-1:0]);
  assign key_ok    = (wr_data == DW'(challenge + SECRET[DW-1:0]));
  assign rise      = hit_ctrl && wr_data[0] && !dm_active;
  assign wr_accept = wr_en && (authed || hit_key || hit_ctrl);
  assign lfsr_nxt  = {1'b0, lfsr_q[DW-1:1]} ^ (lfsr_q[0] ? TAPS[DW-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q     <= SEED[DW-1:0];
      challenge  <= SEED[DW-1:0];
      authed     <= !REQUIRE_AUTH;
      dm_active  <= 1'b0;
      halt_req   <= 1'b0;
      resume_req <= 1'b0;
      hart_reset <= 1'b0;
      sys_reset  <= 1'b0;
      hart_sel   <= '0;
    end else begin
      lfsr_q <= lfsr_nxt;
      if (rise) begin
        dm_active  <= 1'b1;
        authed     <= !REQUIRE_AUTH;
        challenge  <= lfsr_q;
        halt_req   <= !REQUIRE_AUTH && wr_data[31];
        resume_req <= !REQUIRE_AUTH && wr_data[30];
        hart_reset <= !REQUIRE_AUTH && wr_data[29];
        sys_reset  <= !REQUIRE_AUTH && wr_data[1];
        hart_sel   <= REQUIRE_AUTH ? '0 : wr_data[HSEL_LSB +: HSW];
      end else if (hit_ctrl) begin
        dm_active <= wr_data[0];
        if (authed && wr_data[0]) begin
          halt_req   <= wr_data[31];
          resume_req <= wr_data[30];
          hart_reset <= wr_data[29];
          sys_reset  <= wr_data[1];
          hart_sel   <= wr_data[HSEL_LSB +: HSW];
        end
      end else if (hit_key && REQUIRE_AUTH) begin
        if (key_ok) begin
          authed <= 1'b1;
        end else begin
          authed    <= 1'b0;
          challenge <= lfsr_q;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_auth_gate_chk.sv
module dbg_auth_gate_chk #(
  parameter int unsigned DW           = 32,
  parameter int unsigned AW           = 7,
  parameter int unsigned HSW          = 10,
  parameter logic [6:0]  KEY_ADDR     = 7'h30,
  parameter logic [6:0]  CTRL_ADDR    = 7'h10,
  parameter logic [31:0] SECRET       = 32'hC3A5_9E71,
  parameter bit          REQUIRE_AUTH = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic           wr_accept,
  input logic           authed,
  input logic [DW-1:0]  challenge,
  input logic [DW-1:0]  lfsr_q,
  input logic           dm_active,
  input logic           halt_req,
  input logic [HSW-1:0] hart_sel
);
  logic is_key, is_ctrl;
  assign is_key  = wr_en && (wr_addr == KEY_ADDR[AW-1:0]);
  assign is_ctrl = wr_en && (wr_addr == CTRL_ADDR[AW-1:0]);

  assert_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (REQUIRE_AUTH == 1'b0) |-> authed);

  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (REQUIRE_AUTH && is_key && wr_data == DW'(challenge + SECRET[DW-1:0])) |=> authed);

  assert_wrong_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (REQUIRE_AUTH && is_key && wr_data != DW'(challenge + SECRET[DW-1:0]))
      |=> (!authed && challenge == $past(lfsr_q)));

  assert_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!authed && !is_key && !is_ctrl) |-> !wr_accept);

  assert_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> wr_en);

  assert_locked_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (REQUIRE_AUTH && is_ctrl && !authed && dm_active)
      |=> ($stable(halt_req) && $stable(hart_sel) && dm_active == $past(wr_data[0])));

  assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && wr_data[0] && !dm_active)
      |=> (dm_active && challenge == $past(lfsr_q) && authed == !REQUIRE_AUTH));

  assert_chal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_key || is_ctrl) |=> $stable(challenge));

  assert_gen_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

bind dbg_auth_gate dbg_auth_gate_chk #(
  .DW(DW), .AW(AW), .HSW(HSW), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
  .SECRET(SECRET), .REQUIRE_AUTH(REQUIRE_AUTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_accept(wr_accept), .authed(authed), .challenge(challenge), .lfsr_q(lfsr_q),
  .dm_active(dm_active), .halt_req(halt_req), .hart_sel(hart_sel)
);

// File: tb/tb_dbg_auth_gate.sv
module tb_dbg_auth_gate;
  localparam logic [6:0]  KEY  = 7'h30;
  localparam logic [6:0]  CTRL = 7'h10;
  localparam logic [31:0] SEC  = 32'hC3A5_9E71;
  localparam logic [31:0] SEED = 32'h1ACE_B00C;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [6:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic acc, au, act, hr, rr, hrs, srs, acc_o, au_o, act_o, hr_o, rr_o, hrs_o, srs_o;
  logic [31:0] chal, chal_o;
  logic [9:0] hs, hs_o;

  always #2 clk = ~clk;

  dbg_auth_gate dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_accept(acc), .authed(au), .challenge(chal), .dm_active(act),
    .halt_req(hr), .resume_req(rr), .hart_reset(hrs), .sys_reset(srs), .hart_sel(hs));

  dbg_auth_gate #(.REQUIRE_AUTH(1'b0)) dut_open (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_accept(acc_o), .authed(au_o),
    .challenge(chal_o), .dm_active(act_o), .halt_req(hr_o), .resume_req(rr_o),
    .hart_reset(hrs_o), .sys_reset(srs_o), .hart_sel(hs_o));

  logic [31:0] gen;
  always @(posedge clk) gen <= !rst_n ? SEED : ({1'b0, gen[31:1]} ^ (gen[0] ? 32'h8020_0003 : 32'h0));

  int errors = 0, checks = 0;
  logic e_au, e_act;
  logic [31:0] e_chal;
  logic [13:0] e_fld;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [13:0] fields_of(logic [31:0] d);
    return {d[31], d[30], d[29], d[1], d[25:16]};
  endfunction

  task automatic check_state(string req);
    check({req, " authed"}, {31'b0, au}, {31'b0, e_au});
    check({req, " challenge"}, chal, e_chal);
    check({req, " active"}, {31'b0, act}, {31'b0, e_act});
    check({req, " fields"}, {18'b0, hr, rr, hrs, srs, hs}, {18'b0, e_fld});
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d, string req, bit full);
    logic [31:0] snap;
    logic was_au;
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    snap = gen; was_au = e_au;
    #1;
    check({req, " accept"}, {31'b0, acc}, {31'b0, (was_au || a == KEY || a == CTRL)});
    if (a == CTRL && d[0] && !e_act) begin
      e_act = 1; e_au = 0; e_chal = snap; e_fld = '0;
    end else if (a == CTRL) begin
      e_act = d[0];
      if (was_au && d[0]) e_fld = fields_of(d);
    end else if (a == KEY) begin
      if (d == e_chal + SEC) e_au = 1;
      else begin e_au = 0; e_chal = snap; end
    end
    @(negedge clk);
    wr_en = 0;
    if (full) check_state(req);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    e_au = 0; e_act = 0; e_chal = SEED; e_fld = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check_state("R9 reset");
    check("R1 open reset", {31'b0, au_o}, 32'd1);
    repeat (5) @(negedge clk);
    check_state("R8 idle hold");

    for (int a = 0; a < 128; a++) wr(7'(a), 32'h0, "R4 locked sweep", a == KEY);
    wr(CTRL, 32'hFFFF_FFFF, "R6 rise locked", 1);
    wr(CTRL, 32'hFFFF_FFFF, "R5 locked fields", 1);
    wr(CTRL, 32'hE3FF_0003, "R5 locked fields 2", 1);

    wr(KEY, e_chal + SEC + 32'd1, "R3 off+1", 1);
    wr(KEY, e_chal + SEC - 32'd1, "R3 off-1", 1);
    wr(KEY, e_chal + SEC + 32'h8000_0000, "R3 msb", 1);
    wr(KEY, SEC, "R3 secret only", 1);
    wr(KEY, e_chal + SEC, "R2 unlock", 1);
    wr(KEY, e_chal + SEC, "R2 repeat", 1);

    for (int a = 0; a < 128; a++) if (a != KEY) wr(7'(a), 32'h0, "R4 open sweep", a == CTRL);
    wr(KEY, e_chal + SEC, "R2 relock", 1);
    wr(CTRL, 32'h0000_0001, "R6 rise authed", 1);
    wr(KEY, e_chal + SEC, "R2 unlock again", 1);
    wr(CTRL, 32'h8001_0003, "R7 pattern a", 1);
    wr(CTRL, 32'h6200_0001, "R7 pattern b", 1);
    wr(CTRL, 32'hE3FF_0003, "R7 pattern c", 1);
    wr(CTRL, 32'h1234_5670, "R7 deactivate holds", 1);
    wr(CTRL, 32'h8001_0003, "R6 rise clears", 1);
    wr(KEY, e_chal + SEC + 32'd7, "R3 wrong after rise", 1);
    repeat (4) @(negedge clk);
    check_state("R8 idle hold 2");
    check("R1 open still authed", {31'b0, au_o}, 32'd1);
    check("R1 open fields", {18'b0, hr_o, rr_o, hrs_o, srs_o, hs_o}, {18'b0, fields_of(32'h8001_0003)});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule